// File: doc/BRIEF.md
# Gray-Addressed Streaming SRAM Writer

This block pours a burst of data words into an asynchronous static RAM at a rate of one word per clock. It does not pulse the write strobe for each word. The strobe and the chip select stay active for the whole burst, and each new write starts when the address moves by one Gray code position. Only one address line toggles between two writes, so the memory never sees a glitching intermediate address.

A burst begins with a one-cycle `start` pulse carrying a binary start address and a word count. After a single setup cycle, the upstream side feeds words over a valid/ready handshake. Each accepted word places its Gray address on the rising clock edge and its data on the following falling edge, which leaves the memory half a cycle per write. The burst stops when the word count runs out, or earlier if upstream valid drops. In either case the strobe is released a fixed time later while the address stays put, and a one-cycle `done` pulse follows.

Top module: `gray_stream_sram_writer`

## Requirements
- R1: After reset, `sram_we_n` and `sram_cs_n` are 1 (inactive, both active-low), `s_ready` is 0 and `done` is 0.
- R2: A `start` pulse while idle with a nonzero `burst_len` drives `sram_we_n` and `sram_cs_n` to 0 and `sram_addr` to the Gray code of `start_addr` (gray = b XOR (b >> 1)) at the next rising edge. `s_ready` stays 0 for that first setup cycle.
- R3: The word accepted at the k-th handshake (`s_valid` and `s_ready` both 1 at a rising edge, k counted from 0) is written at address gray(`start_addr` + k) and carries that word's data. Outside a handshake the address does not move while the strobe is active.
- R4: The address presented at two successive writes of a burst differs in exactly one bit.
- R5: `sram_we_n` remains 0 continuously from the setup cycle through every word of the burst, with no per-word pulse.
- R6: `sram_addr` changes on the rising edge of a handshake, while `sram_data` still holds the previous word until the following falling edge.
- R7: After the edge E that ends a burst, `sram_we_n` and `sram_cs_n` rise at edge E+2 and `sram_addr` keeps the last written address across that release.
- R8: `done` is 1 for exactly one cycle, from edge E+3 to edge E+4, after the strobe has been inactive for a full cycle.
- R9: If `s_valid` is 0 at a rising edge while streaming, that edge ends the burst early. No further word is accepted and `s_ready` stays 0.
- R10: A `start` pulse while a burst is in progress is ignored. It changes neither the addresses nor the word count of that burst.
- R11: A `start` pulse with `burst_len` = 0 is ignored. The strobe stays inactive and no `done` follows.
- R12: `s_ready` is 1 only while streaming, and never while the strobe is inactive.
- R13: The address counter wraps modulo 2^ADDR_W, and the Gray step across the wrap is still a single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; address launched on rising edge, data on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a burst |
| start_addr | input | ADDR_W | Binary address of the first word |
| burst_len | input | LEN_W | Number of words in the burst |
| s_valid | input | 1 | Upstream word valid |
| s_data | input | DATA_W | Upstream word |
| s_ready | output | 1 | Writer can take a word this cycle |
| sram_addr | output | ADDR_W | Gray-coded memory address |
| sram_data | output | DATA_W | Memory write data, launched on falling edge |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_we_n | output | 1 | Active-low write enable, held for the burst |
| done | output | 1 | One-cycle pulse after the burst has closed |

## Verification
Bursts run from a mid-range address, from just below the top of the address space so the count wraps, and with a single word, so the length-one boundary is covered. Each pairing of address and data is compared against a scoreboard. A burst cut short by a valid drop, and one in which valid never comes, show whether the early-end path and the full-count path produce the same release and done timing, each offset by its own end edge. A start pulse injected in the middle of a burst, and a start carrying a zero length, show whether requests the writer must ignore can disturb the address or the strobe. The data bus is sampled just after each rising edge and again after the falling edge, which separates a correct half-cycle data launch from data that moves together with its address.

// File: rtl/gsw_pkg.sv
`timescale 1ns/1ps
package gsw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_SETUP  = 3'd1,
    WS_STREAM = 3'd2,
    WS_DRAIN  = 3'd3,
    WS_FLUSH  = 3'd4,
    WS_HOLD   = 3'd5
  } wr_state_e;

endpackage

// File: rtl/gsw_gray_counter.sv
`timescale 1ns/1ps
module gsw_gray_counter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_bin,
  input  logic              step,
  output logic [ADDR_W-1:0] gray_q
);

  function automatic logic [ADDR_W-1:0] to_gray(input logic [ADDR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [ADDR_W-1:0] bin_next_q;

  // gray_q is a register fed from the binary counter, so the pins never see
  // the ripple of the adder.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_next_q <= '0;
      gray_q     <= '0;
    end else if (load) begin
      bin_next_q <= load_bin;
      gray_q     <= to_gray(load_bin);
    end else if (step) begin
      gray_q     <= to_gray(bin_next_q);
      bin_next_q <= bin_next_q + 1'b1;
    end
  end

endmodule

// File: rtl/gsw_burst_ctrl.sv
`timescale 1ns/1ps
module gsw_burst_ctrl
  import gsw_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             load,
  output logic             accept,
  output logic             burst_end,
  output logic             strobe_on,
  output logic             done_q
);

  wr_state_e        state_q, state_d;
  logic [LEN_W-1:0] remain_q;

  assign s_ready   = (state_q == WS_STREAM);
  assign load      = start && (state_q == WS_IDLE) && (burst_len != '0);
  assign accept    = s_ready && s_valid;
  assign burst_end = s_ready && (!s_valid || remain_q == LEN_W'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:   if (load) state_d = WS_SETUP;
      WS_SETUP:  state_d = WS_STREAM;
      WS_STREAM: if (burst_end) state_d = WS_DRAIN;
      WS_DRAIN:  state_d = WS_FLUSH;
      WS_FLUSH:  state_d = WS_HOLD;
      WS_HOLD:   state_d = WS_IDLE;
      default:   state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      remain_q  <= '0;
      strobe_on <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      strobe_on <= (state_d == WS_SETUP) || (state_d == WS_STREAM) ||
                   (state_d == WS_DRAIN) || (state_d == WS_FLUSH);
      done_q    <= (state_q == WS_HOLD);
      if (load)
        remain_q <= burst_len;
      else if (accept)
        remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/gsw_dual_edge_launch.sv
`timescale 1ns/1ps
module gsw_dual_edge_launch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] launch_q
);

  logic [DATA_W-1:0] rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rise_q <= '0;
    else if (capture)
      rise_q <= cap_data;
  end

  // Half a cycle after the address register moves, the word follows.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      launch_q <= '0;
    else
      launch_q <= rise_q;
  end

endmodule

// File: rtl/gray_stream_sram_writer.sv
`timescale 1ns/1ps
module gray_stream_sram_writer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_data,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              done
);

  logic load_evt;
  logic accept_evt;
  logic end_evt;
  logic strobe_on;

  gsw_burst_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .burst_len (burst_len),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .load      (load_evt),
    .accept    (accept_evt),
    .burst_end (end_evt),
    .strobe_on (strobe_on),
    .done_q    (done)
  );

  gsw_gray_counter #(.ADDR_W(ADDR_W)) addr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_bin (start_addr),
    .step     (accept_evt),
    .gray_q   (sram_addr)
  );

  gsw_dual_edge_launch #(.DATA_W(DATA_W)) data_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept_evt),
    .cap_data (s_data),
    .launch_q (sram_data)
  );

  assign sram_we_n = ~strobe_on;
  assign sram_cs_n = ~strobe_on;

endmodule

// File: rtl/gsw_checker.sv
`timescale 1ns/1ps
module gsw_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              accept,
  input logic              burst_end,
  input logic              done,
  input logic              sram_we_n,
  input logic              sram_cs_n,
  input logic [ADDR_W-1:0] sram_addr
);

  AST_READY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!sram_we_n && !sram_cs_n)); // R12

  AST_GRAY_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n) && sram_addr != $past(sram_addr))
      |-> $countones(sram_addr ^ $past(sram_addr)) == 1); // R4

  AST_ADDR_MOVES_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n) && !$past(accept)) |-> $stable(sram_addr)); // R3

  AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !sram_we_n); // R5

  AST_ADDR_HELD_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> $stable(sram_addr)); // R7

  AST_ADDR_HELD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> $stable(sram_addr)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sram_we_n && $past(sram_we_n))); // R8

  AST_END_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !s_ready); // R9

endmodule

bind gray_stream_sram_writer gsw_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_ready   (s_ready),
  .accept    (accept_evt),
  .burst_end (end_evt),
  .done      (done),
  .sram_we_n (sram_we_n),
  .sram_cs_n (sram_cs_n),
  .sram_addr (sram_addr)
);

// File: tb/gray_stream_sram_writer_tb_top.sv
`timescale 1ns/1ps
module gray_stream_sram_writer_tb_top;

  localparam int CLK_PERIOD = 12;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] burst_len = '0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_ready;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_data;
  logic          sram_cs_n;
  logic          sram_we_n;
  logic          done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [AW+DW-1:0] exp_q[$];
  logic             hs_prev = 1'b0;
  logic [DW-1:0]    last_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gray_stream_sram_writer #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .burst_len(burst_len), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .sram_addr(sram_addr), .sram_data(sram_data),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .done(done)
  );

  // Gray code restated bit by bit: bit i is the xor of binary bits i and i+1.
  function automatic logic [AW-1:0] ref_gray(input logic [AW-1:0] b);
    logic [AW-1:0] g;
    for (int i = 0; i < AW; i++)
      g[i] = (i == AW-1) ? b[i] : (b[i] != b[i+1]);
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: a quarter period after each falling edge, settle the write
  // launched by the preceding rising edge, then note the upcoming handshake.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (hs_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected write", 32'(sram_addr), 32'hffff_ffff);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          check(sram_addr == e[AW+DW-1:DW], "R3 R4 R13 write address",
                32'(sram_addr), 32'(e[AW+DW-1:DW]));
          check(sram_data == e[DW-1:0], "R3 write data", 32'(sram_data),
                32'(e[DW-1:0]));
          check(!sram_we_n && !sram_cs_n, "R5 strobe held on write",
                32'({sram_we_n, sram_cs_n}), 32'd0);
          last_data = sram_data;
        end
      end
      hs_prev = rst_n && s_valid && s_ready;
    end
  end

  // R6: just after a handshake edge the data bus still shows the prior word.
  initial begin
    forever begin
      logic hs_edge;
      @(posedge clk);
      hs_edge = hs_prev;
      #(CLK_PERIOD/4);
      if (hs_edge)
        check(sram_data == last_data, "R6 data waits for falling edge",
              32'(sram_data), 32'(last_data));
    end
  end

  task automatic run_burst(input logic [AW-1:0] a0, input logic [LW-1:0] len,
                           input int nsend, input bit poke);
    int extra;
    logic [AW-1:0] last_a;
    @(negedge clk);
    start = 1'b1; start_addr = a0; burst_len = len;
    @(negedge clk);
    start = 1'b0; start_addr = ~a0;
    check(!sram_we_n && !sram_cs_n, "R2 strobe on after start",
          32'({sram_we_n, sram_cs_n}), 32'd0);
    check(sram_addr == ref_gray(a0), "R2 start address", 32'(sram_addr),
          32'(ref_gray(a0)));
    check(!s_ready, "R2 R12 ready low in setup", 32'(s_ready), 32'd0);
    for (int i = 0; i < nsend; i++) begin
      logic [DW-1:0] w;
      w = {a0, 8'(i)} ^ 16'h5a3c;
      s_valid = 1'b1; s_data = w;
      exp_q.push_back({ref_gray(a0 + AW'(i)), w});
      while (!s_ready) @(negedge clk);
      if (poke && i == 1) begin
        start = 1'b1; start_addr = 8'h05; burst_len = 8'd9;
      end
      @(negedge clk);
      start = 1'b0;
    end
    s_valid = 1'b0;
    if (nsend == int'(len)) extra = 0;
    else if (nsend == 0) extra = 2;
    else extra = 1;
    last_a = (nsend == 0) ? ref_gray(a0) : ref_gray(a0 + AW'(nsend - 1));
    repeat (extra) @(negedge clk);
    check(!sram_we_n, "R5 strobe still on after last word", 32'(sram_we_n), 32'd0);
    @(negedge clk);
    check(!sram_we_n && !s_ready, "R7 R9 strobe on, ready off in flush",
          32'({sram_we_n, s_ready}), 32'd0);
    @(negedge clk);
    check(sram_we_n && sram_cs_n, "R7 strobe released at E+2",
          32'({sram_we_n, sram_cs_n}), 32'd3);
    check(sram_addr == last_a, "R7 address held at release", 32'(sram_addr),
          32'(last_a));
    check(!done, "R8 done not yet", 32'(done), 32'd0);
    @(negedge clk);
    check(done, "R8 done pulse at E+3", 32'(done), 32'd1);
    check(sram_addr == last_a, "R7 address held after release", 32'(sram_addr),
          32'(last_a));
    @(negedge clk);
    check(!done && !s_ready && sram_we_n, "R8 R12 done cleared, idle",
          32'({done, s_ready, sram_we_n}), 32'd1);
    check(exp_q.size() == 0, "R3 R9 all expected words written",
          32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sram_we_n && sram_cs_n && !s_ready && !done, "R1 reset state",
          32'({sram_we_n, sram_cs_n, s_ready, done}), 32'hc);
    rst_n = 1'b1;
    @(negedge clk);
    check(sram_we_n && !s_ready, "R1 R12 idle after reset",
          32'({sram_we_n, s_ready}), 32'd2);

    run_burst(8'h10, 8'd5, 5, 1'b0);   // R3 R4 plain burst
    run_burst(8'hFE, 8'd4, 4, 1'b0);   // R13 wrap across top
    run_burst(8'h33, 8'd6, 3, 1'b0);   // R9 valid drop
    run_burst(8'h40, 8'd1, 1, 1'b0);   // single word
    run_burst(8'h20, 8'd3, 0, 1'b0);   // R9 valid never arrives
    run_burst(8'h80, 8'd4, 4, 1'b1);   // R10 start during burst

    // R11: zero length start is ignored
    @(negedge clk);
    start = 1'b1; start_addr = 8'h7; burst_len = 8'd0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(sram_we_n && !done && !s_ready, "R11 zero length ignored",
            32'({sram_we_n, done, s_ready}), 32'd4);
      @(negedge clk);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule